// File: doc/BRIEF.md
# Short Pulse Capture Synchronizer

This block brings a single asynchronous event line into the system clock domain. It does not lose an event when the high time of the line is much shorter than one system clock period. A sticky capture flop is clocked by the rising edge of the asynchronous line itself, with its data tied to one, so any rising edge is held however brief the pulse. A chain of system-clock flops then carries the held level across the domain boundary. The chain gives a full clock period of settling time per stage.

Once the captured level reaches the last synchronizer stage, that stage clears the capture flop asynchronously, so one input edge yields exactly one event. Users see two outputs. The first is a synchronized level that stays high while the event passes through the last stage. The second is a one-cycle event pulse marking the rising edge of that level. The block suits interrupt lines, strobes from slow peripherals and pulses from other clock domains, provided that distinct events are spaced several system clocks apart.

Top module: `pulse_catch_sync`

## Requirements
- R1: Each rising edge of `evt_async` that arrives while the block is idle produces exactly one `evt_pulse`, for any high time of the input, including high times of 1 ns against the 8 ns clock.
- R2: `evt_pulse` is high for exactly one clock cycle per event, and only in the first cycle in which `evt_level` is high.
- R3: While `evt_level` is high the capture flop is held cleared. Further rising edges of `evt_async` that arrive while a capture is pending, or while `evt_level` is high, merge into the same single event.
- R4: With an input edge placed between two clock edges, `evt_level` rises after the SYNC_STAGES-th following rising clock edge (the 2nd with the default). It then stays high for SYNC_STAGES cycles.
- R5: While `rst` (synchronous, active high) is asserted, `evt_level` and `evt_pulse` are 0 and the capture flop is held cleared. Input edges during reset produce no event after reset is released.
- R6: Only the rising edge of `evt_async` counts. Holding the input high for many clock cycles gives one event, and the falling edge gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also clears the capture flop |
| evt_async | input | 1 | Asynchronous event line; its rising edge is captured |
| evt_level | output | 1 | Synchronized event level |
| evt_pulse | output | 1 | One-cycle pulse per captured event |

## Verification
The main function is driven with single input pulses of widths from 1 ns, well under a clock period, up to several clock periods. Each pulse is sampled cycle by cycle, which tells a lost narrow pulse apart from a duplicated wide one and exposes any shift in the latency. Doubled edges are placed in three windows: before the first clock edge, between the capture and the clear, and while the clear is active. These confirm that pending edges merge into one event. A further pattern raises the input during reset and shows that reset also empties the capture flop.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int unsigned PCS_MIN_STAGES = 2;

    typedef struct packed {
        logic prev;
    } edge_state_t;

endpackage

// File: rtl/pcs_capture.sv
module pcs_capture (
    input  logic edge_i,
    input  logic clr_i,
    output logic held_o
);

    logic held_q;

    // Sticky flop: any rising edge sets it, the clear empties it.
    always_ff @(posedge edge_i or posedge clr_i) begin
        if (clr_i) begin
            held_q <= 1'b0;
        end else begin
            held_q <= 1'b1;
        end
    end

    assign held_o = held_q;

endmodule

// File: rtl/pcs_sync_chain.sv
module pcs_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] stage;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage[LAST];

    // R5: reset empties every stage
    p_chain_reset_r5: assert property (@(posedge clk)
        rst |=> (st_q.stage == '0));

endmodule

// File: rtl/pcs_edge_det.sv
module pcs_edge_det
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);

    edge_state_t es_d, es_q;

    always_comb begin
        es_d      = es_q;
        es_d.prev = level_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            es_q <= '0;
        end else begin
            es_q <= es_d;
        end
    end

    assign pulse_o = level_i & ~es_q.prev;

    // R2: the event pulse never lasts two cycles
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // R2: pulse only when the level has just risen
    p_pulse_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (level_i && !$past(level_i)));

endmodule

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync
    import pcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_async,
    output logic evt_level,
    output logic evt_pulse
);

    logic held;
    logic clr;
    logic level;

    assign clr = rst | level;

    pcs_capture u_capture (
        .edge_i (evt_async),
        .clr_i  (clr),
        .held_o (held)
    );

    pcs_sync_chain #(.STAGES(SYNC_STAGES)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (held),
        .dout (level)
    );

    pcs_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .pulse_o (evt_pulse)
    );

    assign evt_level = level;

    initial begin
        assert (SYNC_STAGES >= PCS_MIN_STAGES)
            else $error("SYNC_STAGES below minimum");
    end

    // R3: capture flop held empty while the level is seen
    p_capture_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        level |-> !held);

    // R4: level stays high at least two cycles once raised
    p_level_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |=> level);

    // R5: outputs quiet after a reset cycle
    p_reset_quiet_r5: assert property (@(posedge clk)
        rst |=> (!evt_level && !evt_pulse));

endmodule

// File: tb/test_pulse_catch_sync.sv
`timescale 1ns/1ps
module test_pulse_catch_sync;

    localparam int STAGES  = 2;
    localparam int NVEC    = 10;
    localparam int WINDOW  = 8;

    // {pulse width ns, second edge offset ns (0 = none), expected events}
    localparam int VEC [NVEC][3] = '{
        '{1,  0, 1},
        '{2,  0, 1},
        '{3,  0, 1},
        '{5,  0, 1},
        '{9,  0, 1},
        '{20, 0, 1},
        '{40, 0, 1},
        '{1,  2, 1},
        '{2,  6, 1},
        '{3, 14, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt_async = 1'b0;
    logic evt_level;
    logic evt_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pulse_catch_sync #(.SYNC_STAGES(STAGES)) i_pulse_catch_sync (
        .clk       (clk),
        .rst       (rst),
        .evt_async (evt_async),
        .evt_level (evt_level),
        .evt_pulse (evt_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int w, input int off);
        evt_async = 1'b1;
        #(w);
        evt_async = 1'b0;
        if (off > 0) begin
            #(off - w);
            evt_async = 1'b1;
            #1;
            evt_async = 1'b0;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int npulse;
        int nlevel;
        int first_lvl;
        repeat (3) @(negedge clk);
        // R5: reset state
        chk("R5 reset level", int'(evt_level), 0);
        chk("R5 reset pulse", int'(evt_pulse), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            npulse = 0; nlevel = 0; first_lvl = 0;
            #1;
            fork
                drive(VEC[v][0], VEC[v][1]);
            join_none
            for (int c = 1; c <= WINDOW; c++) begin
                @(negedge clk);
                if (evt_pulse) npulse++;
                if (evt_level) begin
                    nlevel++;
                    if (first_lvl == 0) first_lvl = c;
                    // R2: pulse only in the first high cycle
                    if (nlevel > 1) chk("R2 pulse late", int'(evt_pulse), 0);
                end
            end
            // R1, R3, R6: one event per idle edge, merged edges
            chk("R1/R3 event count", npulse, VEC[v][2]);
            // R4: latency and level width
            chk("R4 latency", first_lvl, STAGES);
            chk("R4 level width", nlevel, STAGES);
        end

        // R6: input held high for many cycles, then fall
        npulse = 0;
        evt_async = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (evt_pulse) npulse++;
        end
        evt_async = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (evt_pulse) npulse++;
        end
        chk("R6 long high single event", npulse, 1);

        // R5: edge during reset yields no event
        rst = 1'b1;
        @(negedge clk);
        #1 evt_async = 1'b1;
        #2 evt_async = 1'b0;
        npulse = 0;
        @(negedge clk);
        chk("R5 level in reset", int'(evt_level), 0);
        rst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (evt_pulse || evt_level) npulse++;
        end
        chk("R5 no event after reset", npulse, 0);

        // R1: block works again after reset
        npulse = 0;
        #1 evt_async = 1'b1;
        #1 evt_async = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (evt_pulse) npulse++;
        end
        chk("R1 event after reset", npulse, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule